// File: doc/BRIEF.md
# SPI Data FIFO Pair with Ready Thresholds

This block sits between a 32-bit register port and a byte-wide serial shift engine and buffers data in both directions. The transmit side accepts whole 32-bit words from the register port and hands them to the engine one byte at a time, lowest byte first. The receive side collects bytes from the engine and returns them to the register port packed into 32-bit words, again with the earliest byte in the lowest position. Each direction holds eight bytes.

Software sees a 12-bit status vector: a ready bit per direction, with a programmable 3-bit threshold; empty and full bits; and four sticky error flags for pushes into a full FIFO and pops from an empty one. For a transfer word of B bytes, software normally programs the receive threshold to B-1 and the transmit threshold to 7-B. A final transmit word with fewer than four meaningful bytes is padded with 0xFF in its unused upper bytes, so a short tail never writes stray data. A flush request empties both FIFOs, and its busy indication drops by itself once the flush is done.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty and no error flag is set. The status vector then reads 0x058 with both thresholds at 3, and `flush_busy` is 0. Status bits 1 and 0 always read 0.
- R2: A word pushed through `wr_push` reaches the engine as four bytes in little-endian order: bits [7:0] first, bits [31:24] last. While the transmit FIFO holds data, `eng_tx_byte` shows the oldest byte, and `eng_tx_take` removes it.
- R3: `wr_nbytes` holds the count of meaningful bytes minus one. Every byte above that count is replaced by 0xFF before storage, and all four bytes are always queued.
- R4: `rd_data` shows the oldest received bytes packed little-endian. `rd_pop` removes up to four bytes. When fewer than four are held, the missing upper bytes read as zero.
- R5: Status bit 3 (transmit ready) is 1 when the free byte count exceeds `cfg_wr_thr`. Status bit 2 (receive ready) is 1 when the held byte count exceeds `cfg_rd_thr`.
- R6: Status bit 4 is receive empty (0 bytes) and bit 5 is receive full (8 bytes). Bit 6 is transmit empty (0 bytes) and bit 7 is transmit full (fewer than 4 bytes free, so no word fits).
- R7: A push with fewer than four bytes free is discarded and sets the sticky transmit-overflow flag, status bit 11.
- R8: A received byte arriving while eight bytes are held is discarded and sets the sticky receive-overflow flag, status bit 9.
- R9: A register pop from an empty receive FIFO sets status bit 8, and `rd_data` keeps the last word popped. An engine take from an empty transmit FIFO sets status bit 10, and `eng_tx_byte` keeps the last byte taken.
- R10: Error flags stay set until cleared through `err_clr`. Its bits 0 to 3 clear status bits 8 to 11 in that order. A new error in the same cycle wins over the clear.
- R11: A `flush_req` pulse raises `flush_busy` for exactly one cycle, after which both FIFOs are empty. Pushes, pops, takes and received bytes in the request cycle or the busy cycle are ignored and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_thr | input | 3 | Receive ready threshold in bytes |
| cfg_wr_thr | input | 3 | Transmit ready threshold in bytes |
| flush_req | input | 1 | Pulse to empty both FIFOs |
| flush_busy | output | 1 | High while a flush is in progress |
| wr_push | input | 1 | Push `wr_data` into the transmit FIFO |
| wr_nbytes | input | 2 | Meaningful bytes in `wr_data` minus one |
| wr_data | input | 32 | Transmit word, little-endian |
| rd_pop | input | 1 | Remove the word shown on `rd_data` |
| rd_data | output | 32 | Oldest received bytes, little-endian |
| eng_tx_take | input | 1 | Engine consumes `eng_tx_byte` |
| eng_tx_byte | output | 8 | Next byte to shift out |
| eng_rx_put | input | 1 | Engine delivers `eng_rx_byte` |
| eng_rx_byte | input | 8 | Received byte |
| err_clr | input | 4 | Clear mask for the sticky error flags |
| status | output | 12 | Ready, empty, full and error bits |

## Verification
The properties assume the thresholds stay constant around the cycles they check. They also assume that, in the cycle of an empty-FIFO register pop, the engine does not deliver a received byte, since the held-data property would otherwise see a new word. The stimulus changes thresholds only while no access is in flight. It drives every access at the falling edge and holds it for exactly one rising edge. It never overlaps a receive put with an empty pop, and the only access it combines with a flush is one deliberately ignored push.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int WORD_BYTES = 4;
  localparam int STATUS_W   = 12;

  // status bit positions
  localparam int ST_RD_RDY  = 2;
  localparam int ST_WR_RDY  = 3;
  localparam int ST_RD_EMP  = 4;
  localparam int ST_RD_FULL = 5;
  localparam int ST_WR_EMP  = 6;
  localparam int ST_WR_FULL = 7;
  localparam int ST_ERR_LO  = 8;

  // error flag order inside the 4-bit error group
  localparam int ERR_RD_UNF = 0;
  localparam int ERR_RD_OVF = 1;
  localparam int ERR_WR_UNF = 2;
  localparam int ERR_WR_OVF = 3;

  // bytes above last_idx become 0xFF
  function automatic logic [8*WORD_BYTES-1:0] pad_tail(
      input logic [8*WORD_BYTES-1:0] w, input logic [1:0] last_idx);
    logic [8*WORD_BYTES-1:0] r;
    for (int k = 0; k < WORD_BYTES; k++)
      r[8*k +: 8] = (k <= int'(last_idx)) ? w[8*k +: 8] : 8'hFF;
    return r;
  endfunction

  // only the lowest n bytes survive, the rest read as zero
  function automatic logic [8*WORD_BYTES-1:0] keep_low(
      input logic [8*WORD_BYTES-1:0] w, input int n);
    logic [8*WORD_BYTES-1:0] r;
    for (int k = 0; k < WORD_BYTES; k++)
      r[8*k +: 8] = (k < n) ? w[8*k +: 8] : 8'h00;
    return r;
  endfunction

endpackage

// File: rtl/spi_fifo_bytes.sv
module spi_fifo_bytes #(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANE_W = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [LANE_W-1:0]  push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic [LANE_W-1:0]  pop_n,
  output logic [8*LANES-1:0] head_data,
  output logic [CNT_W-1:0]   level
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (k < int'(push_n))
          mem[wr_ptr + PTR_W'(k)] <= push_data[8*k +: 8];
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      level  <= level + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++)
      head_data[8*k +: 8] = mem[rd_ptr + PTR_W'(k)];
  end

endmodule

// File: rtl/spi_fifo_errflags.sv
module spi_fifo_errflags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

endmodule

// File: rtl/spi_fifo_flush.sv
module spi_fifo_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy <= 1'b0;
    else if (busy) busy <= 1'b0;
    else           busy <= req;
  end

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH_BYTES = 8,
  parameter int THR_W       = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [THR_W-1:0]        cfg_rd_thr,
  input  logic [THR_W-1:0]        cfg_wr_thr,
  input  logic                    flush_req,
  output logic                    flush_busy,
  input  logic                    wr_push,
  input  logic [1:0]              wr_nbytes,
  input  logic [8*WORD_BYTES-1:0] wr_data,
  input  logic                    rd_pop,
  output logic [8*WORD_BYTES-1:0] rd_data,
  input  logic                    eng_tx_take,
  output logic [7:0]              eng_tx_byte,
  input  logic                    eng_rx_put,
  input  logic [7:0]              eng_rx_byte,
  input  logic [3:0]              err_clr,
  output logic [STATUS_W-1:0]     status
);

  localparam int CNT_W  = $clog2(DEPTH_BYTES + 1);
  localparam int LANE_W = $clog2(WORD_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH_BYTES);
  localparam logic [CNT_W-1:0] WORD_LVL = CNT_W'(WORD_BYTES);

  // named internal events
  logic frozen;
  logic tx_push_ok, tx_push_bad, tx_take_ok, tx_take_bad;
  logic rx_put_ok, rx_put_bad, rx_pop_ok, rx_pop_bad;

  logic [CNT_W-1:0]          tx_level, rx_level, tx_free;
  logic [8*WORD_BYTES-1:0]   tx_head, rx_head;
  logic [LANE_W-1:0]         rx_take_n;
  logic [7:0]                last_tx_byte;
  logic [8*WORD_BYTES-1:0]   last_rd_word;
  logic [3:0]                err_set, err_q;

  assign frozen   = flush_req | flush_busy;
  assign tx_free  = FULL_LVL - tx_level;

  assign tx_push_ok  = wr_push & ~frozen & (tx_free >= WORD_LVL);
  assign tx_push_bad = wr_push & ~frozen & (tx_free <  WORD_LVL);
  assign tx_take_ok  = eng_tx_take & ~frozen & (tx_level != '0);
  assign tx_take_bad = eng_tx_take & ~frozen & (tx_level == '0);
  assign rx_put_ok   = eng_rx_put & ~frozen & (rx_level != FULL_LVL);
  assign rx_put_bad  = eng_rx_put & ~frozen & (rx_level == FULL_LVL);
  assign rx_pop_ok   = rd_pop & ~frozen & (rx_level != '0);
  assign rx_pop_bad  = rd_pop & ~frozen & (rx_level == '0);

  assign rx_take_n = (rx_level >= WORD_LVL) ? LANE_W'(WORD_BYTES) : LANE_W'(rx_level);

  spi_fifo_flush u_flush (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (flush_req),
    .busy (flush_busy)
  );

  spi_fifo_bytes #(.DEPTH(DEPTH_BYTES), .LANES(WORD_BYTES)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush_busy),
    .push_n   (tx_push_ok ? LANE_W'(WORD_BYTES) : LANE_W'(0)),
    .push_data(pad_tail(wr_data, wr_nbytes)),
    .pop_n    (tx_take_ok ? LANE_W'(1) : LANE_W'(0)),
    .head_data(tx_head),
    .level    (tx_level)
  );

  spi_fifo_bytes #(.DEPTH(DEPTH_BYTES), .LANES(WORD_BYTES)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (flush_busy),
    .push_n   (rx_put_ok ? LANE_W'(1) : LANE_W'(0)),
    .push_data({{(8*WORD_BYTES-8){1'b0}}, eng_rx_byte}),
    .pop_n    (rx_pop_ok ? rx_take_n : LANE_W'(0)),
    .head_data(rx_head),
    .level    (rx_level)
  );

  always_comb begin
    err_set             = '0;
    err_set[ERR_RD_UNF] = rx_pop_bad;
    err_set[ERR_RD_OVF] = rx_put_bad;
    err_set[ERR_WR_UNF] = tx_take_bad;
    err_set[ERR_WR_OVF] = tx_push_bad;
  end

  spi_fifo_errflags #(.N(4)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (err_set),
    .clr  (err_clr),
    .flags(err_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tx_byte <= '0;
      last_rd_word <= '0;
    end else begin
      if (tx_take_ok) last_tx_byte <= tx_head[7:0];
      if (rx_pop_ok)  last_rd_word <= keep_low(rx_head, int'(rx_take_n));
    end
  end

  assign eng_tx_byte = (tx_level != '0) ? tx_head[7:0] : last_tx_byte;
  assign rd_data     = (rx_level != '0) ? keep_low(rx_head, int'(rx_take_n)) : last_rd_word;

  always_comb begin
    status                          = '0;
    status[ST_RD_RDY]               = rx_level > CNT_W'(cfg_rd_thr);
    status[ST_WR_RDY]               = tx_free  > CNT_W'(cfg_wr_thr);
    status[ST_RD_EMP]               = rx_level == '0;
    status[ST_RD_FULL]              = rx_level == FULL_LVL;
    status[ST_WR_EMP]               = tx_level == '0;
    status[ST_WR_FULL]              = tx_free < WORD_LVL;
    status[ST_ERR_LO +: 4]          = err_q;
  end

endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush_req,
  input logic        flush_busy,
  input logic        wr_push,
  input logic        rd_pop,
  input logic        eng_rx_put,
  input logic [31:0] rd_data,
  input logic [3:0]  err_clr,
  input logic [11:0] status
);

  // R6
  rd_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[5] && status[4]));

  // R6
  wr_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[7] && status[6]));

  // R7
  wr_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_push && !flush_req && !flush_busy && status[7]) |=> status[11]);

  // R9
  rd_underflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !eng_rx_put && !flush_req && !flush_busy && status[4])
      |=> (status[8] && $stable(rd_data)));

  // R10
  rd_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[9] && !err_clr[1]) |=> status[9]);

  // R11
  flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> (!flush_busy && status[4] && status[6]));

endmodule

bind spi_fifo_pair spi_fifo_pair_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_req (flush_req),
  .flush_busy(flush_busy),
  .wr_push   (wr_push),
  .rd_pop    (rd_pop),
  .eng_rx_put(eng_rx_put),
  .rd_data   (rd_data),
  .err_clr   (err_clr),
  .status    (status)
);

// File: tb/spi_fifo_pair_test.sv
`timescale 1ns/1ps
module spi_fifo_pair_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_rd_thr = 3'd3, cfg_wr_thr = 3'd3;
  logic        flush_req = 1'b0, flush_busy;
  logic        wr_push = 1'b0;
  logic [1:0]  wr_nbytes = 2'd3;
  logic [31:0] wr_data = '0, rd_data;
  logic        rd_pop = 1'b0, eng_tx_take = 1'b0, eng_rx_put = 1'b0;
  logic [7:0]  eng_tx_byte, eng_rx_byte = '0;
  logic [3:0]  err_clr = '0;
  logic [11:0] status;

  int checks = 0, fails = 0;
  bit finished = 0;

  // scoreboard state
  logic [7:0]  tx_q[$];
  logic [7:0]  rx_q[$];
  logic [7:0]  last_tx = 8'h00;
  logic [31:0] last_rd = 32'h0;

  always #5 clk = ~clk;

  spi_fifo_pair uut (
    .clk(clk), .rst_n(rst_n), .cfg_rd_thr(cfg_rd_thr), .cfg_wr_thr(cfg_wr_thr),
    .flush_req(flush_req), .flush_busy(flush_busy), .wr_push(wr_push),
    .wr_nbytes(wr_nbytes), .wr_data(wr_data), .rd_pop(rd_pop), .rd_data(rd_data),
    .eng_tx_take(eng_tx_take), .eng_tx_byte(eng_tx_byte), .eng_rx_put(eng_rx_put),
    .eng_rx_byte(eng_rx_byte), .err_clr(err_clr), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // driver: push a word, record the bytes the engine must see
  task automatic push(input logic [31:0] w, input logic [1:0] nb, input bit fits);
    @(negedge clk);
    wr_push = 1'b1; wr_data = w; wr_nbytes = nb;
    @(negedge clk);
    wr_push = 1'b0;
    if (fits)
      for (int k = 0; k < 4; k++)
        tx_q.push_back(k <= int'(nb) ? w[8*k +: 8] : 8'hFF);
  endtask

  // monitor on the engine side
  task automatic take(input string req);
    logic [7:0] e;
    @(negedge clk);
    if (tx_q.size() > 0) begin e = tx_q.pop_front(); last_tx = e; end
    else e = last_tx;
    chk(req, {24'h0, eng_tx_byte}, {24'h0, e});
    eng_tx_take = 1'b1;
    @(negedge clk);
    eng_tx_take = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input bit fits);
    @(negedge clk);
    eng_rx_put = 1'b1; eng_rx_byte = b;
    @(negedge clk);
    eng_rx_put = 1'b0;
    if (fits) rx_q.push_back(b);
  endtask

  // monitor on the register side
  task automatic pop(input string req);
    logic [31:0] e;
    int n;
    @(negedge clk);
    n = (rx_q.size() < 4) ? rx_q.size() : 4;
    if (n == 0) e = last_rd;
    else begin
      e = '0;
      for (int k = 0; k < n; k++) e[8*k +: 8] = rx_q.pop_front();
      last_rd = e;
    end
    chk(req, rd_data, e);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic clear_err(input logic [3:0] m);
    @(negedge clk);
    err_clr = m;
    @(negedge clk);
    err_clr = '0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", {20'h0, status}, 32'h058);
    chk("R1 flush_busy", {31'h0, flush_busy}, 32'h0);

    // R2 byte order
    push(32'h44332211, 2'd3, 1);
    chk("R5 R6 one word queued", {20'h0, status}, 32'h018);
    for (int i = 0; i < 4; i++) take("R2 byte order");
    chk("R6 tx empty again", {20'h0, status}, 32'h058);

    // R7 overflow on a full transmit FIFO
    push(32'hA3A2A1A0, 2'd3, 1);
    push(32'hB3B2B1B0, 2'd3, 1);
    chk("R6 tx full", {20'h0, status}, 32'h090);
    push(32'hDEADBEEF, 2'd3, 0);
    chk("R7 overflow flag", {20'h0, status}, 32'h890);
    for (int i = 0; i < 8; i++) take("R7 data intact");
    chk("R10 overflow sticky", {20'h0, status}, 32'h858);

    // R3 padding of a short tail
    push(32'hAABBCCDD, 2'd1, 1);
    for (int i = 0; i < 4; i++) take("R3 pad bytes");
    take("R9 tx underflow holds byte");
    chk("R9 tx underflow flag", {20'h0, status}, 32'hC58);
    clear_err(4'b1100);
    chk("R10 clear", {20'h0, status}, 32'h058);

    // R8 receive overflow, R4 packing
    for (int i = 1; i <= 8; i++) put(8'(i), 1);
    chk("R5 R6 rx full", {20'h0, status}, 32'h06C);
    put(8'h09, 0);
    chk("R8 rx overflow flag", {20'h0, status}, 32'h26C);
    pop("R4 pack word 1");
    pop("R4 pack word 2");
    chk("R10 rx ovf sticky", {20'h0, status}, 32'h258);
    clear_err(4'b0010);

    // R5 receive threshold
    put(8'hA1, 1); put(8'hA2, 1); put(8'hA3, 1);
    chk("R5 rx below threshold", {20'h0, status}, 32'h048);
    put(8'hA4, 1);
    chk("R5 rx above threshold", {20'h0, status}, 32'h04C);
    pop("R4 full word");
    put(8'hAA, 1); put(8'hBB, 1);
    pop("R4 partial word");
    chk("R4 rx empty", {20'h0, status}, 32'h058);
    pop("R9 rd underflow holds word");
    chk("R9 rd underflow flag", {20'h0, status}, 32'h158);
    clear_err(4'b0001);

    // R5 transmit threshold
    @(negedge clk); cfg_wr_thr = 3'd5;
    @(negedge clk);
    chk("R5 tx ready thr5", {20'h0, status}, 32'h058);
    push(32'h0D0C0B0A, 2'd3, 1);
    chk("R5 tx not ready thr5", {20'h0, status}, 32'h010);
    for (int i = 0; i < 4; i++) take("R2 after thr");
    @(negedge clk); cfg_wr_thr = 3'd3;

    // R11 flush with an ignored push
    put(8'h55, 1); put(8'h66, 1);
    push(32'h77777777, 2'd3, 1);
    @(negedge clk);
    flush_req = 1'b1; wr_push = 1'b1; wr_data = 32'h12345678;
    @(negedge clk);
    flush_req = 1'b0; wr_push = 1'b0;
    chk("R11 busy one cycle", {31'h0, flush_busy}, 32'h1);
    @(negedge clk);
    chk("R11 busy cleared", {31'h0, flush_busy}, 32'h0);
    chk("R11 both empty", {20'h0, status}, 32'h058);
    tx_q.delete(); rx_q.delete();
    push(32'h87654321, 2'd3, 1);
    for (int i = 0; i < 4; i++) take("R11 works after flush");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule